// File: doc/BRIEF.md
# Vertical-Dependent Drive Phase Correction

This block produces a per-line phase offset for a horizontal drive pulse generator. The offset is a second-order polynomial in the vertical position of the current line, measured from the screen centre. A linear (tilt) coefficient rotates the raster. A quadratic (bow) coefficient bends it symmetrically top to bottom. A base phase is added to the polynomial. The result saturates to a signed 12-bit range in sub-clock units.

The polynomial is evaluated without multipliers in the per-line path. A frame-start strobe loads the accumulators with the value and the first difference for the top line. Each line strobe then adds the first difference to the value and adds the constant second difference to the first difference. The coefficients and the base phase are sampled only at frame start, so a field is never bent by a register write part way down the screen.

Top module: `vert_phase_corr`

## Requirements
- R1: While `rst_n` is low at a clock edge, `phase_out` becomes 0 and `phase_valid` becomes 0 on that edge.
- R2: `phase_valid` is 1 in exactly the clock after a cycle with `line_start`=1 and `frame_start`=0. In every other cycle it is 0. `phase_out` changes only when `phase_valid` rises with a new value, and otherwise holds.
- R3: The first line strobe after a frame start is line n=0. Each later line strobe increments n. The vertical position is y = n - CENTER_LINE (default 288). A new frame start restarts n at 0.
- R4: For line n, `phase_out` = base + floor((A*256*y + B*y*y) / 4096). A is the tilt coefficient and B the bow coefficient. Both are signed 8-bit two's complement. The base is signed 12-bit two's complement.
- R5: With A=0, lines at y and -y give the same `phase_out`.
- R6: A result above 2047 is output as 2047. A result below -2048 is output as -2048.
- R7: `tilt_coef`, `bow_coef` and `base_phase` are sampled only in a cycle with `frame_start`=1. Changing them at any other time has no effect on the outputs until the next frame start.
- R8: A `line_start` in the same cycle as `frame_start` is ignored: no valid pulse, and the line count of the new frame starts at the next strobe.
- R9: Line strobes after reset and before the first frame start produce `phase_out`=0 with a valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe at the start of a field |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| tilt_coef | input | 8 | Signed linear (tilt) coefficient |
| bow_coef | input | 8 | Signed quadratic (bow) coefficient |
| base_phase | input | 12 | Signed base phase in sub-clock units |
| phase_out | output | 12 | Signed saturated phase offset for the current line |
| phase_valid | output | 1 | One-cycle pulse marking a new `phase_out` |

## Verification
The block is tried with several coefficient patterns, each against a behavioural model that evaluates the polynomial directly for every line:
- A tilt-only frame exposes errors in the linear difference or in the centre offset.
- A bow-only frame exposes errors in the second difference, and is checked for top-to-bottom symmetry.
- Large same-sign coefficients drive the result into both saturation limits.
- Line strobes spaced one and three cycles apart show that the stepping does not depend on line spacing.
- Coefficients changed during a frame, a frame start that collides with a line strobe, and a short frame followed at once by a new frame separate the sampling and restart rules from the arithmetic.

// File: rtl/vpc_pkg.sv
// Shared widths and types for the vertical phase correction block.
package vpc_pkg;
    localparam int COEF_W = 8;   // signed tilt/bow coefficient width
    localparam int OUT_W  = 12;  // signed phase offset width

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [OUT_W-1:0]  phase_t;
endpackage

// File: rtl/vpc_coef_shadow.sv
// Holds the coefficients and base phase for the current field.
// Assumes: frame_start is a single-cycle strobe. The effective outputs
// pass the incoming values through in the frame-start cycle, so that
// the accumulator initialisation sees the new field's coefficients.
module vpc_coef_shadow
    import vpc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   frame_start,
    input  coef_t  tilt_in,
    input  coef_t  bow_in,
    input  phase_t base_in,
    output coef_t  tilt_eff,
    output coef_t  bow_eff,
    output phase_t base_eff
);
    coef_t  tilt_q;
    coef_t  bow_q;
    phase_t base_q;
    logic   armed;

    // Capture the field's settings on frame start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tilt_q <= '0;
            bow_q  <= '0;
            base_q <= '0;
        end else if (frame_start) begin
            tilt_q <= tilt_in;
            bow_q  <= bow_in;
            base_q <= base_in;
        end
    end

    // Marks that held state has been defined by at least one reset edge.
    always_ff @(posedge clk) armed <= rst_n;

    // Select the incoming values in the frame-start cycle, the held ones otherwise.
    always_comb begin
        tilt_eff = frame_start ? tilt_in : tilt_q;
        bow_eff  = frame_start ? bow_in  : bow_q;
        base_eff = frame_start ? base_in : base_q;
    end

    AST_SHADOW_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !frame_start) |=> ($stable(tilt_q) && $stable(bow_q) && $stable(base_q))); // R7
endmodule

// File: rtl/vpc_fwd_diff.sv
// Forward-difference evaluator for P(y) = Ts*y + B*y*y, with Ts = tilt << K
// and y = n - CENTER_LINE.
// Assumes: fewer than MAX_LINES line strobes per field, so that ACC_W holds
// every intermediate value. The initial values use constant multiplies only.
module vpc_fwd_diff
    import vpc_pkg::*;
#(
    parameter int CENTER_LINE = 288,
    parameter int TILT_SHIFT  = 8,
    parameter int ACC_W       = 31
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_start,
    input  logic                    line_step,
    input  coef_t                   tilt_eff,
    input  coef_t                   bow_eff,
    output logic signed [ACC_W-1:0] acc
);
    localparam logic signed [ACC_W-1:0] CTR    = ACC_W'(CENTER_LINE);
    localparam logic signed [ACC_W-1:0] CTR_SQ = ACC_W'(CENTER_LINE * CENTER_LINE);
    localparam logic signed [ACC_W-1:0] D1_K   = ACC_W'(1 - 2 * CENTER_LINE);

    logic signed [ACC_W-1:0] tilt_x, bow_x, tilt_sc;
    logic signed [ACC_W-1:0] p_init, d1_init;
    logic signed [ACC_W-1:0] d1, d2;
    logic                    armed;

    // Sign-extend the coefficients and scale the tilt to the bow's precision.
    always_comb begin
        tilt_x  = {{(ACC_W-COEF_W){tilt_eff[COEF_W-1]}}, tilt_eff};
        bow_x   = {{(ACC_W-COEF_W){bow_eff[COEF_W-1]}}, bow_eff};
        tilt_sc = tilt_x <<< TILT_SHIFT;
        p_init  = bow_x * CTR_SQ - tilt_sc * CTR;
        d1_init = tilt_sc + bow_x * D1_K;
    end

    // Load the top-line state at frame start, then step once per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            d1  <= '0;
            d2  <= '0;
        end else if (frame_start) begin
            acc <= p_init;
            d1  <= d1_init;
            d2  <= bow_x <<< 1;
        end else if (line_step) begin
            acc <= acc + d1;
            d1  <= d1 + d2;
        end
    end

    // Marks that state has been defined by at least one reset edge.
    always_ff @(posedge clk) armed <= rst_n;

    AST_D2_FIELD_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !frame_start) |=> $stable(d2)); // R7
    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && line_step) |=> (acc == $past(acc) + $past(d1))); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !line_step && !frame_start) |=> ($stable(acc) && $stable(d1))); // R3
endmodule

// File: rtl/vpc_out_stage.sv
// Scales the accumulator down, adds the base phase and saturates to OUT_W
// bits. Registers the result together with a one-cycle valid pulse.
// Assumes: ACC_W - FRAC_SHIFT + 1 is larger than OUT_W.
module vpc_out_stage
    import vpc_pkg::*;
#(
    parameter int ACC_W      = 31,
    parameter int FRAC_SHIFT = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    line_step,
    input  logic signed [ACC_W-1:0] acc,
    input  phase_t                  base_eff,
    output phase_t                  phase_out,
    output logic                    phase_valid
);
    localparam int SC_W  = ACC_W - FRAC_SHIFT;
    localparam int SUM_W = SC_W + 1;
    localparam logic signed [SUM_W-1:0] HI = SUM_W'((1 << (OUT_W-1)) - 1);
    localparam logic signed [SUM_W-1:0] LO = -HI - SUM_W'(1);

    logic signed [SC_W-1:0]  scaled;
    logic signed [SUM_W-1:0] sum;
    phase_t                  clipped;
    logic                    armed;

    // Floor-divide by 2^FRAC_SHIFT, add the base, clip to the output range.
    always_comb begin
        scaled = acc[ACC_W-1:FRAC_SHIFT];
        sum    = {scaled[SC_W-1], scaled} + {{(SUM_W-OUT_W){base_eff[OUT_W-1]}}, base_eff};
        if (sum > HI)      clipped = HI[OUT_W-1:0];
        else if (sum < LO) clipped = LO[OUT_W-1:0];
        else               clipped = sum[OUT_W-1:0];
    end

    // Register the offset on each line step and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_out   <= '0;
            phase_valid <= 1'b0;
        end else begin
            phase_valid <= line_step;
            if (line_step) phase_out <= clipped;
        end
    end

    // Marks that the output has been defined by at least one reset edge.
    always_ff @(posedge clk) armed <= rst_n;

    AST_VALID_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        line_step |=> phase_valid); // R2
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !line_step |=> !phase_valid); // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !line_step) |=> $stable(phase_out)); // R2
    AST_CLIP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (line_step && (sum > HI)) |=> (phase_out == HI[OUT_W-1:0])); // R6
    AST_CLIP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (line_step && (sum < LO)) |=> (phase_out == LO[OUT_W-1:0])); // R6
endmodule

// File: rtl/vert_phase_corr.sv
// Top of the vertical-dependent phase correction. Computes, once per line,
// base + floor((tilt*2^(BOW_SHIFT-TILT_SHIFT)*y + bow*y^2) / 2^BOW_SHIFT),
// with y = line - CENTER_LINE, saturated to a signed 12-bit range.
// Assumes: one-cycle strobes, and fewer than MAX_LINES lines per field.
module vert_phase_corr
    import vpc_pkg::*;
#(
    parameter int CENTER_LINE = 288,
    parameter int MAX_LINES   = 1024,
    parameter int TILT_SHIFT  = 4,
    parameter int BOW_SHIFT   = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_start,
    input  logic                     line_start,
    input  logic signed [COEF_W-1:0] tilt_coef,
    input  logic signed [COEF_W-1:0] bow_coef,
    input  logic signed [OUT_W-1:0]  base_phase,
    output logic signed [OUT_W-1:0]  phase_out,
    output logic                     phase_valid
);
    localparam int YW    = $clog2(MAX_LINES);
    localparam int ACC_W = COEF_W + 2 * YW + 3;
    localparam int K     = BOW_SHIFT - TILT_SHIFT;

    logic                    line_step;
    coef_t                   tilt_eff, bow_eff;
    phase_t                  base_eff;
    logic signed [ACC_W-1:0] acc;

    // A frame start takes priority over a coincident line strobe.
    assign line_step = line_start & ~frame_start;

    vpc_coef_shadow u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .tilt_in     (tilt_coef),
        .bow_in      (bow_coef),
        .base_in     (base_phase),
        .tilt_eff    (tilt_eff),
        .bow_eff     (bow_eff),
        .base_eff    (base_eff)
    );

    vpc_fwd_diff #(
        .CENTER_LINE (CENTER_LINE),
        .TILT_SHIFT  (K),
        .ACC_W       (ACC_W)
    ) u_diff (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_step   (line_step),
        .tilt_eff    (tilt_eff),
        .bow_eff     (bow_eff),
        .acc         (acc)
    );

    vpc_out_stage #(
        .ACC_W       (ACC_W),
        .FRAC_SHIFT  (BOW_SHIFT)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_step   (line_step),
        .acc         (acc),
        .base_eff    (base_eff),
        .phase_out   (phase_out),
        .phase_valid (phase_valid)
    );

    AST_COLLIDE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !phase_valid); // R8
endmodule

// File: tb/sim_vert_phase_corr.sv
// Bench for vert_phase_corr: a behavioural model evaluates the polynomial
// directly per line and is compared with the outputs on every clock.
module sim_vert_phase_corr;
    localparam int CLK_PERIOD = 10;
    localparam int CENTER     = 288;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic              line_start = 1'b0;
    logic signed [7:0]  tilt_coef = '0;
    logic signed [7:0]  bow_coef = '0;
    logic signed [11:0] base_phase = '0;
    logic signed [11:0] phase_out;
    logic              phase_valid;

    int    vectors = 0;
    int    misses  = 0;
    int    cycles  = 0;
    string cur_req = "R1";
    bit    compare_on = 1'b0;
    bit    done = 1'b0;

    // Reference model state
    int  m_tilt = 0, m_bow = 0, m_base = 0, m_n = 0;
    bit  m_started = 1'b0;
    int  exp_out = 0;
    bit  exp_valid = 1'b0;
    int  caps[$];

    vert_phase_corr u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_start  (line_start),
        .tilt_coef   (tilt_coef),
        .bow_coef    (bow_coef),
        .base_phase  (base_phase),
        .phase_out   (phase_out),
        .phase_valid (phase_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int model_value(int a, int b, int base, int n);
        longint y, p, q, v;
        y = longint'(n - CENTER);
        p = longint'(a) * 256 * y + longint'(b) * y * y;
        q = p >>> 12;
        v = longint'(base) + q;
        if (v > 2047) v = 2047;
        if (v < -2048) v = -2048;
        return int'(v);
    endfunction

    // Reference model: advances on each rising edge from the driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tilt = 0; m_bow = 0; m_base = 0; m_n = 0; m_started = 0;
            exp_out = 0; exp_valid = 0;
        end else if (frame_start) begin
            m_tilt = int'(tilt_coef); m_bow = int'(bow_coef); m_base = int'(base_phase);
            m_n = 0; m_started = 1; exp_valid = 0;
        end else if (line_start) begin
            exp_valid = 1;
            exp_out = m_started ? model_value(m_tilt, m_bow, m_base, m_n) : 0;
            m_n++;
        end else begin
            exp_valid = 0;
        end
        compare_on = 1'b1;
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (compare_on && !done) begin
            vectors++;
            if (phase_valid !== exp_valid) begin
                misses++;
                $display("FAIL %s/R2 valid: actual %0b expected %0b at cycle %0d",
                         cur_req, phase_valid, exp_valid, cycles);
            end else if (int'(phase_out) != exp_out || $isunknown(phase_out)) begin
                misses++;
                $display("FAIL %s phase_out: actual %0d expected %0d at cycle %0d",
                         cur_req, phase_out, exp_out, cycles);
            end
            if (phase_valid === 1'b1) caps.push_back(int'(phase_out));
        end
    end

    // Watchdog: an expired run counts as a miss and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            misses++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    task automatic run_frame(input int a, input int b, input int base, input int nlines,
                             input int gap, input bit wiggle, input bit collide);
        @(negedge clk);
        tilt_coef   = 8'(a);
        bow_coef    = 8'(b);
        base_phase  = 12'(base);
        frame_start = 1'b1;
        line_start  = collide;
        @(negedge clk);
        frame_start = 1'b0;
        line_start  = 1'b0;
        caps.delete();
        for (int i = 0; i < nlines; i++) begin
            line_start = 1'b1;
            @(negedge clk);
            line_start = 1'b0;
            if (wiggle) begin
                tilt_coef  = tilt_coef + 8'sd37;
                bow_coef   = bow_coef - 8'sd19;
                base_phase = base_phase + 12'sd211;
            end
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic check_eq(input string req, input int act, input int exp_v);
        vectors++;
        if (act != exp_v) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (4) @(negedge clk);
        check_eq("R1 valid", int'(phase_valid), 0);
        check_eq("R1 out", int'(phase_out), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R9: line strobes before any frame start
        cur_req = "R9";
        for (int i = 0; i < 3; i++) begin
            line_start = 1'b1; @(negedge clk); line_start = 1'b0; @(negedge clk);
        end

        // R4: tilt only, then mixed signs with back-to-back lines
        cur_req = "R4";
        run_frame(37, 0, 100, 600, 2, 1'b0, 1'b0);
        run_frame(-90, 41, -300, 620, 0, 1'b0, 1'b0);

        // R5: bow only, symmetric about the centre line
        cur_req = "R5";
        run_frame(0, -23, -50, 577, 1, 1'b0, 1'b0);
        check_eq("R5 y=-288 vs y=+288", caps[0], caps[576]);
        check_eq("R5 y=-188 vs y=+188", caps[100], caps[476]);
        check_eq("R5 y=-1 vs y=+1", caps[287], caps[289]);

        // R6: saturation at both limits
        cur_req = "R6";
        run_frame(127, 127, 2000, 600, 1, 1'b0, 1'b0);
        check_eq("R6 top clipped high", caps[0], 2047);
        run_frame(-128, -128, -2000, 600, 1, 1'b0, 1'b0);
        check_eq("R6 bottom clipped low", caps[599], -2048);

        // R7: input changes during a field have no effect
        cur_req = "R7";
        run_frame(10, 5, 0, 400, 2, 1'b1, 1'b0);
        check_eq("R7 field uses frame-start values", caps[399], model_value(10, 5, 0, 399));

        // R8: frame start colliding with a line strobe
        cur_req = "R8";
        run_frame(-20, 9, 77, 300, 1, 1'b0, 1'b1);
        check_eq("R8 first line is line 0", caps[0], model_value(-20, 9, 77, 0));

        // R3: short field then immediate restart
        cur_req = "R3";
        run_frame(55, -7, 12, 5, 0, 1'b0, 1'b0);
        run_frame(55, -7, 12, 5, 3, 1'b0, 1'b0);
        check_eq("R3 count restarts", caps[0], model_value(55, -7, 12, 0));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule